// File: doc/BRIEF.md
# Software Prefetch Request Controller

This block sits beside a load pipeline and takes charge of software prefetch operations. Each accepted prefetch gets a tracking slot. The slot starts an address translation and waits for the result. The block then either sends a cache fill request or drops the fill without notice. In both cases it reports the prefetch as complete to the reorder logic, tagged with the pipeline's own ID. Completion follows translation directly and never waits for the line itself to arrive. Prefetches that fault, that target uncached memory, or that find no free fill buffer therefore retire at once and leave the program's behaviour unchanged.

A prefetch carrying a lock prefix is not a valid prefetch. It skips translation and completes with an invalid-opcode exception flag. When an older store that has not yet been written targets the same 4 KiB page, the prefetch is held after translation until that store has gone. Two saturating event counters record fills dropped for lack of buffers and prefetches dropped on a translation fault. Each slot is independent, so completions may come back in any order.

Top module: `swpf_ctrl`

## Requirements
- R1: A prefetch completes (`cmpl_valid` high for one cycle with its `cmpl_id`) once its translation has ended, with no data return involved. Any fill request is issued in the same cycle as the completion.
- R2: A translation response of kind 2 (fault) completes the prefetch with no fill request and `cmpl_excp` low, and increments `fault_cnt`.
- R3: A translation response of kind 1 (miss) neither drops nor completes the prefetch. The slot waits for a later response on the same tag, and a kind 0 (hit) response then finishes it normally.
- R4: On a hit, memory type 2 (uncacheable) or 3 (write-combining), i.e. `tlb_resp_mt[1]` set, completes the prefetch with no fill. Types 0 and 1 request a fill.
- R5: If `fb_avail` is low in the cycle the fill decision is made, no fill is issued, the prefetch still completes, and `drop_cnt` increments.
- R6: A request with `req_lock` high starts no translation, issues no fill and completes with `cmpl_excp` high.
- R7: Prefetches to the same cache line are not merged. Each takes its own slot and issues its own fill request.
- R8: A translated prefetch whose page `req_vaddr[VA_W-1:12]` equals `st_page` while `st_valid` is high does not complete until `st_valid` drops or the page differs. A store to another page does not hold it.
- R9: Up to NUM_SLOTS prefetches are in flight. `req_ready` is low when every slot is busy. Each completion carries the ID given at acceptance, in whatever order the translations finish.
- R10: `drop_cnt` and `fault_cnt` saturate at all ones and never wrap.
- R11: After reset, `cmpl_valid`, `fill_valid` and `tlb_req_valid` are low, both counters are zero and `req_ready` is high.
- R12: A fill request carries the line address `req_vaddr[VA_W-1:6]` in `fill_line` and the write-intent hint in `fill_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Prefetch offered by the load pipeline |
| req_ready | output | 1 | A tracking slot is free |
| req_id | input | ID_W | Pipeline tag returned on completion |
| req_vaddr | input | VA_W | Virtual byte address |
| req_write | input | 1 | Write-intent hint |
| req_lock | input | 1 | Lock prefix present |
| tlb_req_valid | output | 1 | Start translation |
| tlb_req_tag | output | SLOT_W | Slot index for the translation |
| tlb_req_vaddr | output | VA_W | Address to translate |
| tlb_resp_valid | input | 1 | Translation response |
| tlb_resp_tag | input | SLOT_W | Slot the response belongs to |
| tlb_resp_kind | input | 2 | 0 hit, 1 miss (walk pending), 2 fault |
| tlb_resp_mt | input | 2 | Memory type: 0 WB, 1 WT, 2 UC, 3 WC |
| fb_avail | input | 1 | A fill buffer is free |
| st_valid | input | 1 | Older unwritten store present |
| st_page | input | VA_W-12 | Page number of that store |
| cmpl_valid | output | 1 | Completion to the reorder logic |
| cmpl_id | output | ID_W | ID of the completing prefetch |
| cmpl_excp | output | 1 | Invalid-opcode exception |
| fill_valid | output | 1 | Cache fill request |
| fill_line | output | VA_W-6 | Line address of the fill |
| fill_write | output | 1 | Fill with write intent |
| drop_cnt | output | CNT_W | Fills dropped for lack of buffers |
| fault_cnt | output | CNT_W | Prefetches dropped on fault |

## Verification
The bench builds the controller with four slots and 3-bit counters. The small counters let a handful of faulting prefetches drive `fault_cnt` to its ceiling and show that it holds there. With four slots, filling every slot to test `req_ready`, and answering the last translation first to get an out-of-order completion, both take only a few requests. The store-hold, miss-wait and same-line cases are driven directly through the translation and store inputs.

// File: rtl/swpf_pkg.sv
package swpf_pkg;

    typedef enum logic [1:0] {
        XK_HIT   = 2'd0,
        XK_MISS  = 2'd1,
        XK_FAULT = 2'd2
    } xlat_kind_e;

    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_XLAT = 2'd1,
        SL_FIN  = 2'd2,
        SL_EXC  = 2'd3
    } slot_state_e;

    // Types 2 (uncacheable) and 3 (write-combining) must not be filled.
    function automatic logic mt_uncached(input logic [1:0] mt);
        return mt[1];
    endfunction

endpackage

// File: rtl/swpf_pick.sv
module swpf_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o = '0;
                gnt_o[i] = 1'b1;
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/swpf_satcnt.sv
module swpf_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/swpf_slot.sv
module swpf_slot
    import swpf_pkg::*;
#(
    parameter int ID_W   = 6,
    parameter int LINE_W = 42,
    parameter int PAGE_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [ID_W-1:0]   alloc_id_i,
    input  logic [LINE_W-1:0] alloc_line_i,
    input  logic              alloc_wr_i,
    input  logic              alloc_lock_i,
    input  logic              resp_i,
    input  logic [1:0]        resp_kind_i,
    input  logic [1:0]        resp_mt_i,
    input  logic              st_valid_i,
    input  logic [PAGE_W-1:0] st_page_i,
    input  logic              grant_i,
    output logic              free_o,
    output logic              eligible_o,
    output logic [ID_W-1:0]   id_o,
    output logic [LINE_W-1:0] line_o,
    output logic              wr_o,
    output logic              exc_o,
    output logic              fault_o,
    output logic              unc_o
);
    localparam int PG_LO = LINE_W - PAGE_W;

    typedef struct packed {
        slot_state_e       st;
        logic [ID_W-1:0]   id;
        logic [LINE_W-1:0] line;
        logic              wr;
        logic              fault;
        logic              unc;
    } slot_rec_t;

    slot_rec_t slot_d, slot_q;
    logic      page_hit;

    always_comb begin
        slot_d = slot_q;
        unique case (slot_q.st)
            SL_FREE: begin
                if (alloc_i) begin
                    slot_d.id    = alloc_id_i;
                    slot_d.line  = alloc_line_i;
                    slot_d.wr    = alloc_wr_i;
                    slot_d.fault = 1'b0;
                    slot_d.unc   = 1'b0;
                    slot_d.st    = alloc_lock_i ? SL_EXC : SL_XLAT;
                end
            end
            SL_XLAT: begin
                if (resp_i) begin
                    if (resp_kind_i == XK_FAULT) begin
                        slot_d.fault = 1'b1;
                        slot_d.st    = SL_FIN;
                    end else if (resp_kind_i == XK_HIT) begin
                        slot_d.unc = mt_uncached(resp_mt_i);
                        slot_d.st  = SL_FIN;
                    end
                end
            end
            default: begin
                if (grant_i) slot_d.st = SL_FREE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign page_hit   = st_valid_i && (slot_q.line[LINE_W-1:PG_LO] == st_page_i);
    assign free_o     = (slot_q.st == SL_FREE);
    assign exc_o      = (slot_q.st == SL_EXC);
    assign eligible_o = exc_o ||
                        ((slot_q.st == SL_FIN) && (slot_q.fault || !page_hit));
    assign id_o       = slot_q.id;
    assign line_o     = slot_q.line;
    assign wr_o       = slot_q.wr;
    assign fault_o    = slot_q.fault;
    assign unc_o      = slot_q.unc;
endmodule

// File: rtl/swpf_ctrl.sv
module swpf_ctrl #(
    parameter int VA_W      = 48,
    parameter int LINE_OFF  = 6,
    parameter int PAGE_OFF  = 12,
    parameter int NUM_SLOTS = 4,
    parameter int ID_W      = 6,
    parameter int CNT_W     = 16,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int LINE_W = VA_W - LINE_OFF,
    localparam int PAGE_W = VA_W - PAGE_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_lock,
    output logic              tlb_req_valid,
    output logic [SLOT_W-1:0] tlb_req_tag,
    output logic [VA_W-1:0]   tlb_req_vaddr,
    input  logic              tlb_resp_valid,
    input  logic [SLOT_W-1:0] tlb_resp_tag,
    input  logic [1:0]        tlb_resp_kind,
    input  logic [1:0]        tlb_resp_mt,
    input  logic              fb_avail,
    input  logic              st_valid,
    input  logic [PAGE_W-1:0] st_page,
    output logic              cmpl_valid,
    output logic [ID_W-1:0]   cmpl_id,
    output logic              cmpl_excp,
    output logic              fill_valid,
    output logic [LINE_W-1:0] fill_line,
    output logic              fill_write,
    output logic [CNT_W-1:0]  drop_cnt,
    output logic [CNT_W-1:0]  fault_cnt
);
    typedef struct packed {
        logic              cmpl_v;
        logic [ID_W-1:0]   cmpl_id;
        logic              excp;
        logic              fill_v;
        logic [LINE_W-1:0] line;
        logic              wr;
    } out_rec_t;

    out_rec_t out_d, out_q;

    logic [NUM_SLOTS-1:0] s_free, s_elig, s_exc, s_fault, s_unc, s_wr;
    logic [NUM_SLOTS-1:0] free_gnt, fin_gnt;
    logic [ID_W-1:0]      s_id   [NUM_SLOTS];
    logic [LINE_W-1:0]    s_line [NUM_SLOTS];
    logic [SLOT_W-1:0]    free_idx, fin_idx;
    logic                 any_free, fin_any, accept;
    logic                 drop_inc, fault_inc;

    swpf_pick #(.N(NUM_SLOTS)) u_alloc_pick (
        .req_i(s_free), .gnt_o(free_gnt), .idx_o(free_idx), .any_o(any_free)
    );

    swpf_pick #(.N(NUM_SLOTS)) u_fin_pick (
        .req_i(s_elig), .gnt_o(fin_gnt), .idx_o(fin_idx), .any_o(fin_any)
    );

    assign req_ready     = any_free;
    assign accept        = req_valid && any_free;
    assign tlb_req_valid = accept && !req_lock;
    assign tlb_req_tag   = free_idx;
    assign tlb_req_vaddr = req_vaddr;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        swpf_slot #(.ID_W(ID_W), .LINE_W(LINE_W), .PAGE_W(PAGE_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (accept && free_gnt[i]),
            .alloc_id_i   (req_id),
            .alloc_line_i (req_vaddr[VA_W-1:LINE_OFF]),
            .alloc_wr_i   (req_write),
            .alloc_lock_i (req_lock),
            .resp_i       (tlb_resp_valid && (tlb_resp_tag == SLOT_W'(i))),
            .resp_kind_i  (tlb_resp_kind),
            .resp_mt_i    (tlb_resp_mt),
            .st_valid_i   (st_valid),
            .st_page_i    (st_page),
            .grant_i      (fin_gnt[i]),
            .free_o       (s_free[i]),
            .eligible_o   (s_elig[i]),
            .id_o         (s_id[i]),
            .line_o       (s_line[i]),
            .wr_o         (s_wr[i]),
            .exc_o        (s_exc[i]),
            .fault_o      (s_fault[i]),
            .unc_o        (s_unc[i])
        );
    end

    always_comb begin
        out_d     = '0;
        drop_inc  = 1'b0;
        fault_inc = 1'b0;
        if (fin_any) begin
            out_d.cmpl_v  = 1'b1;
            out_d.cmpl_id = s_id[fin_idx];
            out_d.excp    = s_exc[fin_idx];
            out_d.line    = s_line[fin_idx];
            out_d.wr      = s_wr[fin_idx];
            fault_inc     = s_fault[fin_idx];
            if (!s_exc[fin_idx] && !s_fault[fin_idx] && !s_unc[fin_idx]) begin
                if (fb_avail) out_d.fill_v = 1'b1;
                else          drop_inc     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    swpf_satcnt #(.W(CNT_W)) u_drop_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(drop_inc), .cnt_o(drop_cnt)
    );

    swpf_satcnt #(.W(CNT_W)) u_fault_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(fault_inc), .cnt_o(fault_cnt)
    );

    assign cmpl_valid = out_q.cmpl_v;
    assign cmpl_id    = out_q.cmpl_id;
    assign cmpl_excp  = out_q.excp;
    assign fill_valid = out_q.fill_v;
    assign fill_line  = out_q.line;
    assign fill_write = out_q.wr;
endmodule

// File: rtl/swpf_ctrl_chk.sv
module swpf_ctrl_chk #(
    parameter int LINE_W = 42,
    parameter int PAGE_W = 36,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_lock,
    input logic              tlb_req_valid,
    input logic              fb_avail,
    input logic              st_valid,
    input logic [PAGE_W-1:0] st_page,
    input logic              cmpl_valid,
    input logic              cmpl_excp,
    input logic              fill_valid,
    input logic [LINE_W-1:0] fill_line,
    input logic [CNT_W-1:0]  drop_cnt,
    input logic [CNT_W-1:0]  fault_cnt
);
    assert_fill_with_cmpl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (cmpl_valid && !cmpl_excp));

    assert_lock_no_xlat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_lock) |-> !tlb_req_valid);

    assert_xlat_needs_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_valid |-> (req_valid && req_ready));

    assert_fill_needs_fb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $past(fb_avail));

    assert_store_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !($past(st_valid) &&
                         ($past(st_page) == fill_line[LINE_W-1 -: PAGE_W])));

    assert_drop_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == CNT_W'($past(drop_cnt) + 1'b1)));

    assert_fault_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cnt != $past(fault_cnt)) |-> (fault_cnt == CNT_W'($past(fault_cnt) + 1'b1)));
endmodule

bind swpf_ctrl swpf_ctrl_chk #(
    .LINE_W(VA_W - LINE_OFF),
    .PAGE_W(VA_W - PAGE_OFF),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_lock     (req_lock),
    .tlb_req_valid(tlb_req_valid),
    .fb_avail     (fb_avail),
    .st_valid     (st_valid),
    .st_page      (st_page),
    .cmpl_valid   (cmpl_valid),
    .cmpl_excp    (cmpl_excp),
    .fill_valid   (fill_valid),
    .fill_line    (fill_line),
    .drop_cnt     (drop_cnt),
    .fault_cnt    (fault_cnt)
);

// File: tb/swpf_ctrl_bench.sv
`timescale 1ns/1ps
module swpf_ctrl_bench;
    localparam int VA_W  = 48;
    localparam int NS    = 4;
    localparam int ID_W  = 6;
    localparam int CW    = 3;
    localparam int SW    = 2;
    localparam int LW    = VA_W - 6;
    localparam int PW    = VA_W - 12;
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic        lock;
        logic [1:0]  kind;   // 0 hit, 1 miss then hit, 2 fault
        logic [1:0]  mt;
        logic        fb;
        logic        wr;
        logic [47:0] addr;
        logic        exp_fill;
        logic        exp_excp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{lock:1'b0, kind:2'd0, mt:2'd0, fb:1'b1, wr:1'b0, addr:48'h0000_1234_5040, exp_fill:1'b1, exp_excp:1'b0},
        '{lock:1'b0, kind:2'd0, mt:2'd1, fb:1'b1, wr:1'b1, addr:48'h0000_0abc_d0c0, exp_fill:1'b1, exp_excp:1'b0},
        '{lock:1'b0, kind:2'd0, mt:2'd2, fb:1'b1, wr:1'b0, addr:48'h0000_0000_7000, exp_fill:1'b0, exp_excp:1'b0},
        '{lock:1'b0, kind:2'd0, mt:2'd3, fb:1'b1, wr:1'b1, addr:48'h0000_0000_8100, exp_fill:1'b0, exp_excp:1'b0},
        '{lock:1'b0, kind:2'd0, mt:2'd0, fb:1'b0, wr:1'b0, addr:48'h0000_0001_9a40, exp_fill:1'b0, exp_excp:1'b0},
        '{lock:1'b0, kind:2'd2, mt:2'd0, fb:1'b1, wr:1'b0, addr:48'h0000_0002_0000, exp_fill:1'b0, exp_excp:1'b0},
        '{lock:1'b0, kind:2'd1, mt:2'd0, fb:1'b1, wr:1'b1, addr:48'h0000_0003_3fc0, exp_fill:1'b1, exp_excp:1'b0},
        '{lock:1'b1, kind:2'd0, mt:2'd0, fb:1'b1, wr:1'b0, addr:48'h0000_0004_0040, exp_fill:1'b0, exp_excp:1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_ready, req_write = 1'b0, req_lock = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic            tlb_req_valid;
    logic [SW-1:0]   tlb_req_tag;
    logic [VA_W-1:0] tlb_req_vaddr;
    logic            tlb_resp_valid = 1'b0;
    logic [SW-1:0]   tlb_resp_tag = '0;
    logic [1:0]      tlb_resp_kind = '0, tlb_resp_mt = '0;
    logic            fb_avail = 1'b1, st_valid = 1'b0;
    logic [PW-1:0]   st_page = '0;
    logic            cmpl_valid, cmpl_excp, fill_valid, fill_write;
    logic [ID_W-1:0] cmpl_id;
    logic [LW-1:0]   fill_line;
    logic [CW-1:0]   drop_cnt, fault_cnt;

    int total = 0, bad = 0;
    logic [CW-1:0] exp_drop = '0, exp_fault = '0;
    bit finished = 0;

    always #4 clk = ~clk;

    swpf_ctrl #(.VA_W(VA_W), .NUM_SLOTS(NS), .ID_W(ID_W), .CNT_W(CW)) u_swpf_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_vaddr(req_vaddr), .req_write(req_write), .req_lock(req_lock),
        .tlb_req_valid(tlb_req_valid), .tlb_req_tag(tlb_req_tag), .tlb_req_vaddr(tlb_req_vaddr),
        .tlb_resp_valid(tlb_resp_valid), .tlb_resp_tag(tlb_resp_tag),
        .tlb_resp_kind(tlb_resp_kind), .tlb_resp_mt(tlb_resp_mt),
        .fb_avail(fb_avail), .st_valid(st_valid), .st_page(st_page),
        .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id), .cmpl_excp(cmpl_excp),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_write(fill_write),
        .drop_cnt(drop_cnt), .fault_cnt(fault_cnt)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Called at a negedge; returns at the negedge after the request edge.
    task automatic send_req(input logic [ID_W-1:0] id, input logic [47:0] a,
                            input logic wr, input logic lk, output logic [SW-1:0] tag);
        req_valid = 1'b1; req_id = id; req_vaddr = a; req_write = wr; req_lock = lk;
        #1;
        check(req_ready === 1'b1, "R9 ready for new request", 64'(req_ready), 64'd1);
        check(tlb_req_valid === !lk, "R6 translation start vs lock", 64'(tlb_req_valid), 64'(!lk));
        tag = tlb_req_tag;
        @(negedge clk);
        req_valid = 1'b0; req_lock = 1'b0;
    endtask

    task automatic respond(input logic [SW-1:0] tag, input logic [1:0] kind, input logic [1:0] mt);
        tlb_resp_valid = 1'b1; tlb_resp_tag = tag; tlb_resp_kind = kind; tlb_resp_mt = mt;
        @(negedge clk);
        tlb_resp_valid = 1'b0;
    endtask

    task automatic wait_cmpl(output bit got, output logic f, output logic x,
                             output logic [ID_W-1:0] id, output logic [LW-1:0] ln, output logic w);
        got = 0; f = 0; x = 0; id = '0; ln = '0; w = 0;
        for (int k = 0; k < 20; k++) begin
            if (cmpl_valid === 1'b1) begin
                got = 1; f = fill_valid; x = cmpl_excp; id = cmpl_id; ln = fill_line; w = fill_write;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v, input logic [ID_W-1:0] id);
        logic [SW-1:0] tag;
        bit got; logic f, x, w; logic [ID_W-1:0] gid; logic [LW-1:0] ln;
        fb_avail = v.fb;
        send_req(id, v.addr, v.wr, v.lock, tag);
        if (!v.lock) begin
            if (v.kind == 2'd1) begin
                respond(tag, 2'd1, 2'd0);
                for (int k = 0; k < 6; k++) begin
                    check(cmpl_valid === 1'b0, "R3 no completion during walk", 64'(cmpl_valid), 64'd0);
                    @(negedge clk);
                end
                respond(tag, 2'd0, v.mt);
            end else begin
                respond(tag, v.kind, v.mt);
            end
        end
        wait_cmpl(got, f, x, gid, ln, w);
        check(got, "R1 completion after translation", 64'(got), 64'd1);
        check(gid === id, "R9 completion id", 64'(gid), 64'(id));
        check(x === v.exp_excp, "R6 exception flag", 64'(x), 64'(v.exp_excp));
        check(f === v.exp_fill, "R4 R5 R2 fill issued", 64'(f), 64'(v.exp_fill));
        if (v.exp_fill) begin
            check(ln === v.addr[47:6], "R12 fill line", 64'(ln), 64'(v.addr[47:6]));
            check(w === v.wr, "R12 fill write hint", 64'(w), 64'(v.wr));
        end
        if (!v.lock && v.kind == 2'd2 && exp_fault != CMAX) exp_fault++;
        if (!v.lock && v.kind != 2'd2 && !v.mt[1] && !v.fb && exp_drop != CMAX) exp_drop++;
        check(fault_cnt === exp_fault, "R2 fault counter", 64'(fault_cnt), 64'(exp_fault));
        check(drop_cnt === exp_drop, "R5 drop counter", 64'(drop_cnt), 64'(exp_drop));
        @(negedge clk);
        check(cmpl_valid === 1'b0, "R1 single completion pulse", 64'(cmpl_valid), 64'd0);
        fb_avail = 1'b1;
    endtask

    initial begin : watchdog
        for (int c = 0; c < 20000; c++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired act=1 exp=0");
        finish_run();
    end

    initial begin : main
        logic [SW-1:0] t [NS];
        logic [SW-1:0] tg;
        bit got; logic f, x, w; logic [ID_W-1:0] gid; logic [LW-1:0] ln;
        int nfill;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(cmpl_valid === 1'b0, "R11 cmpl after reset", 64'(cmpl_valid), 64'd0);
        check(fill_valid === 1'b0, "R11 fill after reset", 64'(fill_valid), 64'd0);
        check(tlb_req_valid === 1'b0, "R11 tlb req after reset", 64'(tlb_req_valid), 64'd0);
        check(drop_cnt === '0 && fault_cnt === '0, "R11 counters zero", 64'({drop_cnt, fault_cnt}), 64'd0);
        check(req_ready === 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);

        foreach (VECS[i]) run_vec(VECS[i], ID_W'(i + 1));

        // R7: same line, two prefetches, two fills
        send_req(6'd20, 48'h0000_0055_5080, 1'b0, 1'b0, t[0]);
        send_req(6'd21, 48'h0000_0055_5080, 1'b0, 1'b0, t[1]);
        check(t[0] != t[1], "R7 separate slots", 64'(t[1]), 64'(t[0] + 1));
        respond(t[0], 2'd0, 2'd0);
        respond(t[1], 2'd0, 2'd0);
        nfill = 0;
        for (int k = 0; k < 10; k++) begin
            if (fill_valid === 1'b1 && fill_line === 42'h0000_0055_5080 >> 6) nfill++;
            @(negedge clk);
        end
        check(nfill == 2, "R7 two fills same line", 64'(nfill), 64'd2);

        // R8: store to same page holds the prefetch
        st_valid = 1'b1; st_page = 36'h0000_0066_6;
        send_req(6'd30, 48'h0000_0066_6100, 1'b1, 1'b0, tg);
        respond(tg, 2'd0, 2'd0);
        for (int k = 0; k < 8; k++) begin
            check(cmpl_valid === 1'b0, "R8 held by same-page store", 64'(cmpl_valid), 64'd0);
            @(negedge clk);
        end
        st_valid = 1'b0;
        wait_cmpl(got, f, x, gid, ln, w);
        check(got && f === 1'b1 && gid === 6'd30, "R8 proceeds after store", 64'({got, f, gid}), 64'({1'b1, 1'b1, 6'd30}));
        @(negedge clk);

        // R8: store to another page does not hold
        st_valid = 1'b1; st_page = 36'h0000_0077_7;
        send_req(6'd31, 48'h0000_0066_6140, 1'b0, 1'b0, tg);
        respond(tg, 2'd0, 2'd0);
        wait_cmpl(got, f, x, gid, ln, w);
        check(got && gid === 6'd31, "R8 other page not held", 64'({got, gid}), 64'({1'b1, 6'd31}));
        st_valid = 1'b0;
        @(negedge clk);

        // R9: fill all slots, out-of-order completion
        for (int i = 0; i < NS; i++) send_req(ID_W'(40 + i), 48'h0000_0100_0000 + 48'(i * 64), 1'b0, 1'b0, t[i]);
        check(req_ready === 1'b0, "R9 not ready when full", 64'(req_ready), 64'd0);
        respond(t[NS-1], 2'd0, 2'd0);
        wait_cmpl(got, f, x, gid, ln, w);
        check(got && gid === ID_W'(40 + NS - 1), "R9 out-of-order completion", 64'(gid), 64'(40 + NS - 1));
        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready after a slot frees", 64'(req_ready), 64'd1);
        for (int i = 0; i < NS - 1; i++) begin
            respond(t[i], 2'd0, 2'd0);
            wait_cmpl(got, f, x, gid, ln, w);
            check(got && gid === ID_W'(40 + i), "R9 remaining completion id", 64'(gid), 64'(40 + i));
            @(negedge clk);
        end

        // R10: fault counter saturates
        for (int i = 0; i < 9; i++) begin
            send_req(6'd50, 48'h0000_0200_0000, 1'b0, 1'b0, tg);
            respond(tg, 2'd2, 2'd0);
            wait_cmpl(got, f, x, gid, ln, w);
            if (exp_fault != CMAX) exp_fault++;
            check(got && f === 1'b0, "R2 fault completes without fill", 64'({got, f}), 64'({1'b1, 1'b0}));
            @(negedge clk);
        end
        check(fault_cnt === CMAX, "R10 fault counter saturated", 64'(fault_cnt), 64'(CMAX));
        check(fault_cnt === exp_fault, "R10 fault model", 64'(fault_cnt), 64'(exp_fault));

        finish_run();
    end
endmodule